// File: doc/BRIEF.md
# Snooped Write Shadow with Bank Switch Tracking

This block sits beside a host bus capture unit and sees one cycle word per valid strobe. Every host write that lands in ordinary memory is copied out through one of two write ports. One port feeds a main-bank copy and the other feeds an auxiliary-bank copy of the host's 64 KiB address space. The bank is chosen from the address range and from three bank-select switches.

The block learns those switches from the same stream. Host writes into a small I/O window set or clear them. The control part decodes each cycle into a small set of strobes. The datapath part registers the switches and the two write ports, so every write port and switch change appears one clock after the cycle that caused it.

Top module: `snoop_shadow`

## Requirements
- R1: A cycle is taken only when `cycValid` is high. In `cycWord`, bits 25:10 carry the address and bits 7:0 carry the data. Bit 8 gives the direction, where 0 is a host write and 1 is a host read. A cycle with `cycValid` low changes nothing.
- R2: A read cycle (bit 8 = 1) raises neither write enable and leaves all three switches unchanged.
- R3: A write below address 0x0200 goes to the auxiliary port when `storeMode` and `auxZpMode` are both 1. Otherwise it goes to the main port.
- R4: A write to an address from 0x0200 to 0xBFFF, or from 0xD000 to 0xFFFF, goes to the auxiliary port when `storeMode` and `auxWriteMode` are both 1. Otherwise it goes to the main port.
- R5: A write to an address from 0xC000 to 0xCFFF raises neither write enable.
- R6: For each routed write, exactly one write enable is high for exactly one clock, in the cycle after the input cycle. The matching port carries that cycle's address and data in the same clock.
- R7: A write decodes as a switch command when `swEnable` is 1 and (address & 0xFF80) == 0xC000. Low 7 bits 0x00 clear and 0x01 set `storeMode`. Low 7 bits 0x04 clear and 0x05 set `auxWriteMode`. Low 7 bits 0x08 clear and 0x09 set `auxZpMode`. The change is visible one clock later.
- R8: Other offsets in the window have no effect on the switches. So does any window write made while `swEnable` is 0.
- R9: The bank choice for a cycle uses the switch values held before that cycle. A switch changed by one cycle steers the writes of the following cycles.
- R10: A synchronous reset clears all three switches and both write enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycValid | input | 1 | Cycle word present this clock |
| cycWord | input | 26 | Captured bus cycle: address, direction flag, data |
| swEnable | input | 1 | Enables decoding of switch commands |
| mainWe | output | 1 | Write enable into the main-bank copy |
| mainAddr | output | 16 | Main-bank write address |
| mainData | output | 8 | Main-bank write data |
| auxWe | output | 1 | Write enable into the auxiliary-bank copy |
| auxAddr | output | 16 | Auxiliary-bank write address |
| auxData | output | 8 | Auxiliary-bank write data |
| storeMode | output | 1 | First bank-select switch, needed by both routing rules |
| auxWriteMode | output | 1 | Switch that routes general-range writes to the auxiliary bank |
| auxZpMode | output | 1 | Switch that routes writes below 0x0200 to the auxiliary bank |

## Verification
The assertions assume that `cycWord` and `swEnable` are stable whenever `cycValid` is high at a clock edge. They make no assumption about bit 9 or about how dense the cycles are. Back-to-back cycles are legal and expected.

The stimulus changes inputs only on the falling edge, one cycle word per clock. It mixes idle clocks, read cycles and writes across the low page, the switch window, the rest of the I/O range and general memory. Window addresses are weighted toward the six command offsets, so the switches change often while routed writes continue.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int AddrW   = 16;
  localparam int DataW   = 8;
  localparam int AddrLsb = 10;
  localparam int DirBit  = 8;
  localparam int WordW   = AddrLsb + AddrW;
  localparam int SwCount = 3;
  // switch index; index*4 is the clear offset, index*4+1 the set offset
  localparam int SwStore = 0;
  localparam int SwAuxWr = 1;
  localparam int SwAuxZp = 2;
  localparam int OffW    = 7;

  typedef struct packed {
    logic               toMain;
    logic               toAux;
    logic [SwCount-1:0] swSet;
    logic [SwCount-1:0] swClr;
  } ctrl_t;
endpackage

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
(
  input  logic               cycValid,
  input  logic [WordW-1:0]   cycWord,
  input  logic               swEnable,
  input  logic [SwCount-1:0] swState,
  output ctrl_t              strobes
);
  logic [AddrW-1:0] addr;
  logic isWrite, lowPage, ioRange, useAux, inWin;

  always_comb begin
    addr    = cycWord[AddrLsb +: AddrW];
    isWrite = cycValid && !cycWord[DirBit];
    lowPage = addr < 16'h0200;
    ioRange = addr[15:12] == 4'hC;
    useAux  = lowPage ? (swState[SwStore] && swState[SwAuxZp])
                      : (swState[SwStore] && swState[SwAuxWr]);
    inWin   = swEnable && isWrite && ((addr & 16'hFF80) == 16'hC000);
    strobes.toMain = isWrite && !ioRange && !useAux;
    strobes.toAux  = isWrite && !ioRange && useAux;
  end

  for (genvar g = 0; g < SwCount; g++) begin : gDecode
    assign strobes.swClr[g] = inWin && (addr[OffW-1:0] == OffW'(g * 4));
    assign strobes.swSet[g] = inWin && (addr[OffW-1:0] == OffW'(g * 4 + 1));
  end
endmodule

// File: rtl/snoop_dp.sv
module snoop_dp
  import snoop_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [WordW-1:0]   cycWord,
  input  ctrl_t              strobes,
  output logic [SwCount-1:0] swState,
  output logic               mainWe,
  output logic [AddrW-1:0]   mainAddr,
  output logic [DataW-1:0]   mainData,
  output logic               auxWe,
  output logic [AddrW-1:0]   auxAddr,
  output logic [DataW-1:0]   auxData
);
  logic [AddrW-1:0] addr;
  logic [DataW-1:0] data;
  assign addr = cycWord[AddrLsb +: AddrW];
  assign data = cycWord[DataW-1:0];

  for (genvar g = 0; g < SwCount; g++) begin : gSwitch
    always_ff @(posedge clk) begin
      if (rst)                   swState[g] <= 1'b0;
      else if (strobes.swSet[g]) swState[g] <= 1'b1;
      else if (strobes.swClr[g]) swState[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mainWe <= 1'b0;
      auxWe  <= 1'b0;
    end else begin
      mainWe <= strobes.toMain;
      auxWe  <= strobes.toAux;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.toMain) begin
      mainAddr <= addr;
      mainData <= data;
    end
    if (strobes.toAux) begin
      auxAddr <= addr;
      auxData <= data;
    end
  end
endmodule

// File: rtl/snoop_shadow.sv
module snoop_shadow
  import snoop_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cycValid,
  input  logic [WordW-1:0] cycWord,
  input  logic             swEnable,
  output logic             mainWe,
  output logic [AddrW-1:0] mainAddr,
  output logic [DataW-1:0] mainData,
  output logic             auxWe,
  output logic [AddrW-1:0] auxAddr,
  output logic [DataW-1:0] auxData,
  output logic             storeMode,
  output logic             auxWriteMode,
  output logic             auxZpMode
);
  ctrl_t              strobes;
  logic [SwCount-1:0] swState;

  snoop_ctrl u_ctrl (
    .cycValid(cycValid), .cycWord(cycWord), .swEnable(swEnable),
    .swState(swState), .strobes(strobes)
  );

  snoop_dp u_dp (
    .clk(clk), .rst(rst), .cycWord(cycWord), .strobes(strobes),
    .swState(swState),
    .mainWe(mainWe), .mainAddr(mainAddr), .mainData(mainData),
    .auxWe(auxWe), .auxAddr(auxAddr), .auxData(auxData)
  );

  assign storeMode    = swState[SwStore];
  assign auxWriteMode = swState[SwAuxWr];
  assign auxZpMode    = swState[SwAuxZp];
endmodule

// File: rtl/snoop_shadow_chk.sv
module snoop_shadow_chk
  import snoop_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cycValid,
  input logic [WordW-1:0] cycWord,
  input logic             swEnable,
  input logic             mainWe,
  input logic [AddrW-1:0] mainAddr,
  input logic [DataW-1:0] mainData,
  input logic             auxWe,
  input logic [AddrW-1:0] auxAddr,
  input logic [DataW-1:0] auxData,
  input logic             storeMode,
  input logic             auxWriteMode,
  input logic             auxZpMode
);
  logic [AddrW-1:0] cAddr;
  logic             cWrite, cRead;
  logic             cWin;
  assign cAddr  = cycWord[AddrLsb +: AddrW];
  assign cWrite = cycValid && !cycWord[DirBit];
  assign cRead  = !cWrite;
  assign cWin   = swEnable && cWrite && ((cAddr & 16'hFF80) == 16'hC000);

  // R2 and R1: no write port activity after an idle or read cycle
  p_read_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(cRead) |-> !mainWe && !auxWe);

  // R5: the I/O range is never stored
  p_io_unstored_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(cWrite && cAddr[15:12] == 4'hC) |-> !mainWe && !auxWe);

  // R6: at most one port is active, and it carries the previous cycle's fields
  p_one_port_r6: assert property (@(posedge clk) disable iff (rst)
    !(mainWe && auxWe));
  p_main_fields_r6: assert property (@(posedge clk) disable iff (rst)
    mainWe |-> mainAddr == $past(cAddr) && mainData == $past(cycWord[DataW-1:0]));
  p_aux_fields_r6: assert property (@(posedge clk) disable iff (rst)
    auxWe |-> auxAddr == $past(cAddr) && auxData == $past(cycWord[DataW-1:0]));

  // R3 and R9: low-page writes follow the switches held before the cycle
  p_low_aux_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(cWrite && cAddr < 16'h0200 && storeMode && auxZpMode) |-> auxWe);

  // R4: general writes with the auxiliary-write pair set go to the auxiliary port
  p_gen_aux_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(cWrite && cAddr >= 16'h0200 && cAddr[15:12] != 4'hC &&
                         storeMode && auxWriteMode) |-> auxWe);

  // R8: switches hold outside the enabled window
  p_sw_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(!cWin) |-> $stable({storeMode, auxWriteMode, auxZpMode}));

  // R7: a set command for the first switch takes effect
  p_store_set_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(cWin && cAddr[OffW-1:0] == 7'h01) |-> storeMode);

  // R10: reset clears switches and enables
  p_reset_clear_r10: assert property (@(posedge clk)
    $past(rst) |-> !storeMode && !auxWriteMode && !auxZpMode && !mainWe && !auxWe);
endmodule

bind snoop_shadow snoop_shadow_chk u_chk (.*);

// File: tb/sim_snoop_shadow.sv
module sim_snoop_shadow;
  localparam time ClkPeriod = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cycValid = 1'b0;
  logic [25:0] cycWord = '0;
  logic        swEnable = 1'b0;
  logic        mainWe, auxWe, storeMode, auxWriteMode, auxZpMode;
  logic [15:0] mainAddr, auxAddr;
  logic [7:0]  mainData, auxData;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic rS = 0, rW = 0, rZ = 0;   // reference switches

  always #(ClkPeriod / 2) clk = ~clk;

  snoop_shadow u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit routeAux(input logic [15:0] a, input logic s, input logic w, input logic z);
    return (a < 16'h0200) ? (s && z) : (s && w);
  endfunction

  // called at a falling edge; applies one cycle and checks one clock later
  task automatic doCycle(input logic v, input logic wr, input logic [15:0] a,
                         input logic [7:0] d, input logic en, input string tag);
    logic [25:0] w;
    bit isW, io, aux, expMain, expAux, win;
    string rq, fq;
    w = '0; w[25:10] = a; w[7:0] = d; w[8] = ~wr; w[9] = $urandom % 2;
    cycValid = v; cycWord = w; swEnable = en;
    isW = v && wr;
    io  = a[15:12] == 4'hC;
    aux = routeAux(a, rS, rW, rZ);
    expMain = isW && !io && !aux;
    expAux  = isW && !io && aux;
    rq = io ? "R5" : (!isW ? "R2" : (a < 16'h0200 ? "R3" : "R4"));
    if (tag != "") rq = tag;
    win = isW && en && ((a & 16'hFF80) == 16'hC000);
    fq = (tag != "") ? tag : (win ? "R7" : (isW ? "R8" : "R2"));
    if (win) begin
      case (a[6:0])
        7'h00: rS = 0;  7'h01: rS = 1;
        7'h04: rW = 0;  7'h05: rW = 1;
        7'h08: rZ = 0;  7'h09: rZ = 1;
        default: ;
      endcase
    end
    @(negedge clk);
    check(mainWe == expMain && auxWe == expAux, rq, {mainWe, auxWe}, {expMain, expAux});
    if (expMain) check(mainAddr == a && mainData == d, "R6", {mainAddr, mainData}, {a, d});
    if (expAux)  check(auxAddr == a && auxData == d, "R6", {auxAddr, auxData}, {a, d});
    check({storeMode, auxWriteMode, auxZpMode} == {rS, rW, rZ}, fq,
          {storeMode, auxWriteMode, auxZpMode}, {rS, rW, rZ});
    cycValid = 0;
  endtask

  task automatic doReset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    rS = 0; rW = 0; rZ = 0;
    check({storeMode, auxWriteMode, auxZpMode, mainWe, auxWe} == 5'b0, "R10",
          {storeMode, auxWriteMode, auxZpMode, mainWe, auxWe}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240117));
    @(negedge clk);
    doReset();
    // R1: valid low write to a switch command changes nothing
    doCycle(0, 1, 16'hC001, 8'h11, 1, "R1");
    doCycle(1, 1, 16'h0300, 8'h22, 1, "R4");   // plain main write
    doCycle(1, 1, 16'hC001, 8'h00, 1, "R7");   // set store
    doCycle(1, 1, 16'h0150, 8'h33, 1, "R3");   // zp off -> main
    doCycle(1, 1, 16'hC009, 8'h00, 1, "R7");   // set zp
    doCycle(1, 1, 16'h0150, 8'h44, 1, "R3");   // aux
    doCycle(1, 1, 16'h0200, 8'h55, 1, "R4");   // aux write off -> main
    doCycle(1, 1, 16'hC005, 8'h00, 1, "R7");   // set aux write
    doCycle(1, 1, 16'hBFFF, 8'h66, 1, "R4");
    doCycle(1, 1, 16'hD000, 8'h77, 1, "R4");
    doCycle(1, 1, 16'hCFFF, 8'h88, 1, "R5");
    doCycle(1, 1, 16'hC008, 8'h00, 0, "R8");   // disabled decode
    doCycle(1, 1, 16'hC002, 8'h00, 1, "R8");   // unused offset
    doCycle(1, 1, 16'hC080, 8'h00, 1, "R8");   // outside window
    doCycle(1, 0, 16'hC000, 8'h00, 1, "R2");   // read of a command address
    doCycle(1, 0, 16'h0400, 8'h99, 1, "R2");
    doCycle(1, 1, 16'hC008, 8'h00, 1, "R7");   // clear zp
    doCycle(1, 1, 16'h0010, 8'hAA, 1, "R9");   // next cycle already main
    doCycle(1, 1, 16'hC000, 8'h00, 1, "R7");   // clear store
    doCycle(1, 1, 16'hE000, 8'hBB, 1, "R9");   // store off -> main
    doCycle(1, 1, 16'hC001, 8'h00, 1, "R7");
    doCycle(1, 1, 16'hC009, 8'h00, 1, "R7");
    doReset();
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      int sel;
      sel = $urandom % 5;
      case (sel)
        0: a = 16'($urandom % 16'h0200);
        1: a = 16'hC000 | 16'($urandom % 12);
        2: a = 16'hC000 | 16'($urandom % 16'h1000);
        default: a = 16'($urandom);
      endcase
      doCycle(($urandom % 8) != 0, ($urandom % 4) != 0, a, 8'($urandom),
              ($urandom % 8) != 0, "");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule